// File: doc/BRIEF.md
# Paged Address Translation Map

This block sits between a network controller, a host, and an on-board buffer memory. It turns a 24-bit controller-side address into a physical buffer address through a page map. Bits 19:10 of the address pick one of 1024 map slots, bits 9:0 are a byte offset inside a 1024-byte page, and the top four bits play no part. The host goes through the same map for its own accesses, so both sides see the same layout of buffer pages.

Each 16-bit map slot holds three things. Bits 11:0 are a page frame number. Bit 13 chooses between the expansion bus (1) and the on-board memory (0). Bit 15 gives the byte order of the page: 1 means the host's big-endian order, and 0 means the controller's little-endian order. A page marked 0 has the two bytes of every 16-bit word swapped in both directions. Only 256 pages exist on the board, so a frame of 256 or more that points at on-board memory is flagged as out of range and is not wrapped.

The host writes and reads slots through a simple register port. A write changes the stored entry at the next clock edge. Translation of an address is combinational from the stored map.

Top module: `pgxl_top`

## Requirements
- R1: Address bits 23:20 have no effect on any translation result.
- R2: Physical address bits 9:0 equal input address bits 9:0 in the same cycle as the address is applied.
- R3: Physical address bits 21:10 equal bits 11:0 of the map slot indexed by address bits 19:10.
- R4: When bit 13 of the selected slot is 1, the expansion-bus select output is high and the full 12-bit frame is used with no out-of-range flag.
- R5: When bit 13 of the selected slot is 0, the out-of-range flag is high exactly when the frame is 256 or more. A frame of 255 is in range.
- R6: When bit 15 of the selected slot is 0, write data toward memory and read data toward the requester both have their upper and lower bytes exchanged. When bit 15 is 1, both pass unchanged.
- R7: A host map write is seen on the map read port and by lookups from the next cycle on. A lookup of the same slot in the cycle of the write still uses the old entry.
- R8: Controller address 0xFFFFF4 is translated through slot 1023 with byte offset 0x3F4.
- R9: A host-side address is translated through the same map as a controller address, with the same results for the same slot and offset.
- R10: After reset every slot reads 0, so every address maps to frame 0 on board, in range, with bytes swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr_en | input | 1 | Host write strobe for the map slot |
| map_idx | input | 10 | Map slot index used for host read and write |
| map_wdata | input | 16 | Entry value to write |
| map_rdata | output | 16 | Stored entry at map_idx |
| ctl_addr | input | 24 | Controller address |
| ctl_phys | output | 22 | Translated controller physical address (frame, offset) |
| ctl_p2sel | output | 1 | Controller access targets the expansion bus |
| ctl_oor | output | 1 | Controller on-board frame out of range |
| ctl_wd_in | input | 16 | Controller write data |
| ctl_wd_out | output | 16 | Controller write data toward memory, lane-adjusted |
| ctl_mrd_in | input | 16 | Memory read data for the controller access |
| ctl_rd_out | output | 16 | Read data to the controller, lane-adjusted |
| hst_addr | input | 24 | Host address |
| hst_phys | output | 22 | Translated host physical address |
| hst_p2sel | output | 1 | Host access targets the expansion bus |
| hst_oor | output | 1 | Host on-board frame out of range |
| hst_wd_in | input | 16 | Host write data |
| hst_wd_out | output | 16 | Host write data toward memory, lane-adjusted |
| hst_mrd_in | input | 16 | Memory read data for the host access |
| hst_rd_out | output | 16 | Read data to the host, lane-adjusted |

## Verification
A host write to a slot and a controller lookup of that same slot can fall in the same cycle. The bench provokes this by first loading a known entry. It then holds the controller address on that slot while the host writes a different entry. The result is judged before the clock edge, where the old frame must appear, and after it, where the new frame must appear on both the lookup and the map read port.

// File: rtl/pgxl_pkg.sv
package pgxl_pkg;
  localparam int ADDR_W    = 24;
  localparam int SLOT_W    = 10;
  localparam int OFS_W     = 10;
  localparam int ENT_W     = 16;
  localparam int FRM_W     = 12;
  localparam int DATA_W    = 16;
  localparam int ONB_PAGES = 256;
  localparam int BORD_BIT  = 15;
  localparam int LOC_BIT   = 13;
  localparam int NLANE     = 2;
endpackage

// File: rtl/pgxl_map.sv
module pgxl_map #(
  parameter int SLOT_W = pgxl_pkg::SLOT_W,
  parameter int ENT_W  = pgxl_pkg::ENT_W,
  parameter int NRD    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic [ENT_W-1:0]  wr_data,
  input  logic [SLOT_W-1:0] rd_idx [NRD],
  output logic [ENT_W-1:0]  rd_ent [NRD]
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [SLOTS-1:0] slot_hit;
  logic [ENT_W-1:0] ent_flat [SLOTS];

  // one-hot write enable per slot
  always_comb begin
    slot_hit = '0;
    if (wr_en) slot_hit[wr_idx] = 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gen_slot
    logic [ENT_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ent_q <= '0;
      else if (slot_hit[g]) ent_q <= wr_data;
    end
    assign ent_flat[g] = ent_q;
  end

  for (genvar r = 0; r < NRD; r++) begin : gen_rd
    assign rd_ent[r] = ent_flat[rd_idx[r]];
  end
endmodule

// File: rtl/pgxl_lane.sv
module pgxl_lane #(
  parameter int ADDR_W    = pgxl_pkg::ADDR_W,
  parameter int SLOT_W    = pgxl_pkg::SLOT_W,
  parameter int OFS_W     = pgxl_pkg::OFS_W,
  parameter int ENT_W     = pgxl_pkg::ENT_W,
  parameter int FRM_W     = pgxl_pkg::FRM_W,
  parameter int DATA_W    = pgxl_pkg::DATA_W,
  parameter int ONB_PAGES = pgxl_pkg::ONB_PAGES,
  parameter int BORD_BIT  = pgxl_pkg::BORD_BIT,
  parameter int LOC_BIT   = pgxl_pkg::LOC_BIT
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ENT_W-1:0]        ent,
  input  logic [DATA_W-1:0]       wd_in,
  input  logic [DATA_W-1:0]       mrd_in,
  output logic [SLOT_W-1:0]       slot_idx,
  output logic [FRM_W+OFS_W-1:0]  phys,
  output logic                    p2sel,
  output logic                    oor,
  output logic [DATA_W-1:0]       wd_out,
  output logic [DATA_W-1:0]       rd_out
);
  localparam int NBYTE  = DATA_W / 8;
  localparam int IDX_LO = OFS_W;
  localparam int IDX_HI = OFS_W + SLOT_W - 1;

  logic [FRM_W-1:0]  frame;
  logic              swap_en;
  logic [DATA_W-1:0] wd_swp, rd_swp;
  logic              unused_bits;

  assign unused_bits = ^{addr[ADDR_W-1:IDX_HI+1], ent};

  assign slot_idx = addr[IDX_HI:IDX_LO];
  assign frame    = ent[FRM_W-1:0];
  assign p2sel    = ent[LOC_BIT];
  assign swap_en  = ~ent[BORD_BIT];
  assign oor      = ~p2sel & (frame >= FRM_W'(ONB_PAGES));
  assign phys     = {frame, addr[OFS_W-1:0]};

  // byte-lane reversal, both directions
  for (genvar b = 0; b < NBYTE; b++) begin : gen_byte
    assign wd_swp[b*8 +: 8] = wd_in[(NBYTE-1-b)*8 +: 8];
    assign rd_swp[b*8 +: 8] = mrd_in[(NBYTE-1-b)*8 +: 8];
  end

  assign wd_out = swap_en ? wd_swp : wd_in;
  assign rd_out = swap_en ? rd_swp : mrd_in;
endmodule

// File: rtl/pgxl_top.sv
module pgxl_top #(
  parameter int ADDR_W    = pgxl_pkg::ADDR_W,
  parameter int SLOT_W    = pgxl_pkg::SLOT_W,
  parameter int OFS_W     = pgxl_pkg::OFS_W,
  parameter int ENT_W     = pgxl_pkg::ENT_W,
  parameter int FRM_W     = pgxl_pkg::FRM_W,
  parameter int DATA_W    = pgxl_pkg::DATA_W,
  parameter int ONB_PAGES = pgxl_pkg::ONB_PAGES,
  parameter int PHYS_W    = FRM_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_wr_en,
  input  logic [SLOT_W-1:0] map_idx,
  input  logic [ENT_W-1:0]  map_wdata,
  output logic [ENT_W-1:0]  map_rdata,
  input  logic [ADDR_W-1:0] ctl_addr,
  output logic [PHYS_W-1:0] ctl_phys,
  output logic              ctl_p2sel,
  output logic              ctl_oor,
  input  logic [DATA_W-1:0] ctl_wd_in,
  output logic [DATA_W-1:0] ctl_wd_out,
  input  logic [DATA_W-1:0] ctl_mrd_in,
  output logic [DATA_W-1:0] ctl_rd_out,
  input  logic [ADDR_W-1:0] hst_addr,
  output logic [PHYS_W-1:0] hst_phys,
  output logic              hst_p2sel,
  output logic              hst_oor,
  input  logic [DATA_W-1:0] hst_wd_in,
  output logic [DATA_W-1:0] hst_wd_out,
  input  logic [DATA_W-1:0] hst_mrd_in,
  output logic [DATA_W-1:0] hst_rd_out
);
  localparam int NLANE = pgxl_pkg::NLANE;
  localparam int NRD   = NLANE + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  // lane 0: controller, lane 1: host
  logic [ADDR_W-1:0] ln_addr  [NLANE];
  logic [DATA_W-1:0] ln_wdi   [NLANE];
  logic [DATA_W-1:0] ln_mrd   [NLANE];
  logic [PHYS_W-1:0] ln_phys  [NLANE];
  logic              ln_p2    [NLANE];
  logic              ln_oor   [NLANE];
  logic [DATA_W-1:0] ln_wdo   [NLANE];
  logic [DATA_W-1:0] ln_rdo   [NLANE];
  logic [SLOT_W-1:0] rd_idx   [NRD];
  logic [ENT_W-1:0]  rd_ent   [NRD];

  assign ln_addr[0] = ctl_addr;
  assign ln_addr[1] = hst_addr;
  assign ln_wdi[0]  = ctl_wd_in;
  assign ln_wdi[1]  = hst_wd_in;
  assign ln_mrd[0]  = ctl_mrd_in;
  assign ln_mrd[1]  = hst_mrd_in;
  assign rd_idx[NLANE] = map_idx;

  pgxl_map #(.SLOT_W(SLOT_W), .ENT_W(ENT_W), .NRD(NRD)) u_map (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (map_wr_en),
    .wr_idx  (map_idx),
    .wr_data (map_wdata),
    .rd_idx  (rd_idx),
    .rd_ent  (rd_ent)
  );

  for (genvar l = 0; l < NLANE; l++) begin : gen_lane
    pgxl_lane #(
      .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .OFS_W(OFS_W), .ENT_W(ENT_W),
      .FRM_W(FRM_W), .DATA_W(DATA_W), .ONB_PAGES(ONB_PAGES)
    ) u_lane (
      .addr     (ln_addr[l]),
      .ent      (rd_ent[l]),
      .wd_in    (ln_wdi[l]),
      .mrd_in   (ln_mrd[l]),
      .slot_idx (rd_idx[l]),
      .phys     (ln_phys[l]),
      .p2sel    (ln_p2[l]),
      .oor      (ln_oor[l]),
      .wd_out   (ln_wdo[l]),
      .rd_out   (ln_rdo[l])
    );
  end

  assign map_rdata  = rd_ent[NLANE];
  assign ctl_phys   = ln_phys[0];
  assign ctl_p2sel  = ln_p2[0];
  assign ctl_oor    = ln_oor[0];
  assign ctl_wd_out = ln_wdo[0];
  assign ctl_rd_out = ln_rdo[0];
  assign hst_phys   = ln_phys[1];
  assign hst_p2sel  = ln_p2[1];
  assign hst_oor    = ln_oor[1];
  assign hst_wd_out = ln_wdo[1];
  assign hst_rd_out = ln_rdo[1];
endmodule

// File: rtl/pgxl_chk.sv
module pgxl_chk #(
  parameter int ADDR_W = pgxl_pkg::ADDR_W,
  parameter int SLOT_W = pgxl_pkg::SLOT_W,
  parameter int OFS_W  = pgxl_pkg::OFS_W,
  parameter int ENT_W  = pgxl_pkg::ENT_W,
  parameter int FRM_W  = pgxl_pkg::FRM_W,
  parameter int DATA_W = pgxl_pkg::DATA_W,
  parameter int PHYS_W = FRM_W + OFS_W,
  parameter int ONB_W  = OFS_W + 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              map_wr_en,
  input logic [SLOT_W-1:0] map_idx,
  input logic [ENT_W-1:0]  map_wdata,
  input logic [ENT_W-1:0]  map_rdata,
  input logic [ADDR_W-1:0] ctl_addr,
  input logic [PHYS_W-1:0] ctl_phys,
  input logic              ctl_p2sel,
  input logic              ctl_oor,
  input logic [DATA_W-1:0] ctl_wd_in,
  input logic [DATA_W-1:0] ctl_wd_out,
  input logic [ADDR_W-1:0] hst_addr,
  input logic [PHYS_W-1:0] hst_phys,
  input logic              hst_oor
);
  localparam int IDX_HI = OFS_W + SLOT_W - 1;

  // R7
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr_en |=> ($stable(map_idx) -> (map_rdata == $past(map_wdata))));

  // R7
  hold_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !map_wr_en |=> ($stable(map_idx) -> $stable(map_rdata)));

  // R4
  p2_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_p2sel |-> !ctl_oor);

  // R5
  oor_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oor |-> (ctl_phys[PHYS_W-1:ONB_W] != '0));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_phys[OFS_W-1:0] == ctl_addr[OFS_W-1:0]);

  // R9
  lanes_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_addr[IDX_HI:OFS_W] == hst_addr[IDX_HI:OFS_W]) |->
      ((ctl_phys[PHYS_W-1:OFS_W] == hst_phys[PHYS_W-1:OFS_W]) && (ctl_oor == hst_oor)));

  // R6
  lane_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wd_out == ctl_wd_in) || (ctl_wd_out == {ctl_wd_in[7:0], ctl_wd_in[DATA_W-1:8]}));
endmodule

bind pgxl_top pgxl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .map_wr_en  (map_wr_en),
  .map_idx    (map_idx),
  .map_wdata  (map_wdata),
  .map_rdata  (map_rdata),
  .ctl_addr   (ctl_addr),
  .ctl_phys   (ctl_phys),
  .ctl_p2sel  (ctl_p2sel),
  .ctl_oor    (ctl_oor),
  .ctl_wd_in  (ctl_wd_in),
  .ctl_wd_out (ctl_wd_out),
  .hst_addr   (hst_addr),
  .hst_phys   (hst_phys),
  .hst_oor    (hst_oor)
);

// File: tb/tb_pgxl_top.sv
module tb_pgxl_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        map_wr_en;
  logic [9:0]  map_idx;
  logic [15:0] map_wdata, map_rdata;
  logic [23:0] ctl_addr, hst_addr;
  logic [21:0] ctl_phys, hst_phys;
  logic        ctl_p2sel, ctl_oor, hst_p2sel, hst_oor;
  logic [15:0] ctl_wd_in, ctl_wd_out, ctl_mrd_in, ctl_rd_out;
  logic [15:0] hst_wd_in, hst_wd_out, hst_mrd_in, hst_rd_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pgxl_top dut (.*);

  // vector: slot, entry, ctl address, expected phys, p2, oor, swap
  localparam logic [74:0] VEC [8] = '{
    {10'd5,   16'h8003, 24'h0017AB, 22'h000FAB, 1'b0, 1'b0, 1'b0},
    {10'd5,   16'h8003, 24'hA017AB, 22'h000FAB, 1'b0, 1'b0, 1'b0},
    {10'd1023,16'h00FF, 24'hFFFFF4, 22'h03FFF4, 1'b0, 1'b0, 1'b1},
    {10'd2,   16'h0100, 24'h000810, 22'h040010, 1'b0, 1'b1, 1'b1},
    {10'd2,   16'h2100, 24'h000810, 22'h040010, 1'b1, 1'b0, 1'b1},
    {10'd700, 16'hAFFF, 24'h0AF001, 22'h3FFC01, 1'b1, 1'b0, 1'b0},
    {10'd0,   16'h8000, 24'h000000, 22'h000000, 1'b0, 1'b0, 1'b0},
    {10'd1,   16'h0FFF, 24'h0007FF, 22'h3FFFFF, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic map_write(input logic [9:0] idx, input logic [15:0] val);
    @(negedge clk);
    map_wr_en = 1'b1; map_idx = idx; map_wdata = val;
    @(negedge clk);
    map_wr_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; map_wr_en = 1'b0; map_idx = '0; map_wdata = '0;
    ctl_addr = '0; hst_addr = '0;
    ctl_wd_in = 16'h1234; ctl_mrd_in = 16'hBEEF;
    hst_wd_in = 16'h00FF; hst_mrd_in = 16'hC0DE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    map_idx = 10'd1023; ctl_addr = 24'h123456; #1;
    chk("R10 rdata", 32'(map_rdata), 32'h0);
    chk("R10 phys", 32'(ctl_phys), 32'h056);
    chk("R10 oor/p2", {30'd0, ctl_oor, ctl_p2sel}, 32'h0);
    chk("R10 swap", 32'(ctl_wd_out), 32'h3412);

    // table walk
    foreach (VEC[i]) begin
      logic [9:0]  v_slot;
      logic [15:0] v_ent;
      logic [23:0] v_addr;
      logic [21:0] v_phys;
      logic        v_p2, v_oor, v_swp;
      {v_slot, v_ent, v_addr, v_phys, v_p2, v_oor, v_swp} = VEC[i];
      map_write(v_slot, v_ent);
      ctl_addr = v_addr;
      hst_addr = v_addr ^ 24'hF00000;
      #1;
      chk("R7 map readback", 32'(map_rdata), 32'(v_ent));
      chk("R3/R2/R1/R8 ctl phys", 32'(ctl_phys), 32'(v_phys));
      chk("R4 p2sel", 32'(ctl_p2sel), 32'(v_p2));
      chk("R5 oor", 32'(ctl_oor), 32'(v_oor));
      chk("R6 wd lanes", 32'(ctl_wd_out), v_swp ? 32'h3412 : 32'h1234);
      chk("R6 rd lanes", 32'(ctl_rd_out), v_swp ? 32'hEFBE : 32'hBEEF);
      chk("R9/R1 hst phys", 32'(hst_phys), 32'(v_phys));
      chk("R9 hst flags", {30'd0, hst_p2sel, hst_oor}, {30'd0, v_p2, v_oor});
      chk("R9 hst lanes", 32'(hst_rd_out), v_swp ? 32'hDEC0 : 32'hC0DE);
    end

    // R7 write and lookup of the same slot in one cycle
    map_write(10'd9, 16'h8011);
    @(negedge clk);
    ctl_addr = 24'h002400;
    map_wr_en = 1'b1; map_idx = 10'd9; map_wdata = 16'h8022;
    #1;
    chk("R7 same-cycle old phys", 32'(ctl_phys), 32'h4400);
    chk("R7 same-cycle old rdata", 32'(map_rdata), 32'h8011);
    @(negedge clk);
    map_wr_en = 1'b0; #1;
    chk("R7 next-cycle new phys", 32'(ctl_phys), 32'h8800);
    chk("R7 next-cycle new rdata", 32'(map_rdata), 32'h8022);

    // R5 boundary via host lane: frame 255 in range, 256 out
    map_write(10'd3, 16'h80FF);
    hst_addr = 24'h000C00; #1;
    chk("R5 frame 255 host", 32'(hst_oor), 32'h0);
    map_write(10'd3, 16'h8100); #1;
    chk("R5 frame 256 host", 32'(hst_oor), 32'h1);

    // R10 reset clears the map again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    map_idx = 10'd5; ctl_addr = 24'h0017AB; #1;
    chk("R10 cleared rdata", 32'(map_rdata), 32'h0);
    chk("R10 cleared phys", 32'(ctl_phys), 32'h3AB);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule